// File: doc/BRIEF.md
# Command Channel Sequencer

This block sits between a host that wants single register transactions on a power-management serial bus and a register-style bus engine that carries them out. The host offers one request at a time: a bus opcode, a 4-bit slave ID, a 16-bit register address, a length code (bytes minus one) and up to eight write bytes. The sequencer checks the request, turns the bus opcode into a 5-bit engine opcode, and packs a 32-bit command word. For a write it loads the data words first. It then writes the command word, which starts the transfer, and polls the engine's status register until it reports done or until a cycle budget runs out. Last, for a read, it collects the data words, and it replies with an error class.

The state machine has nine states. IDLE accepts a request (IDLE to CHECK). CHECK rejects a bad length or opcode (CHECK to REPLY), or goes on to WR_LO for writes or to ISSUE for reads. WR_LO goes to WR_HI when the length is above four bytes, and otherwise to ISSUE. WR_HI goes to ISSUE, and ISSUE goes to POLL. POLL stays in POLL while the status is not done and the budget is not spent. When done is seen, POLL goes to RD_LO for a clean read, or to REPLY for a write or on any error. An expired budget also takes POLL to REPLY. RD_LO goes to RD_HI for reads above four bytes, and otherwise to REPLY. RD_HI goes to REPLY, and REPLY returns to IDLE.

The engine-side offsets used are these: command 0x00, status 0x08, write data 0x10 (low) and 0x14 (high), read data 0x18 (low) and 0x1C (high). Read data on `bus_rdata` is valid in the same cycle as `bus_rd_en`.

Top module: `cmd_chan_seq`

## Requirements
- R1: For a read (`req_write`=0), bus opcodes 0x60..0x7F become engine opcode 15, 0x20..0x2F become 13, and 0x38..0x3F become 1.
- R2: For a write, bus opcodes 0x40..0x5F become 14, 0x00..0x0F become 2, 0x30..0x37 become 0, and 0x80..0xFF become 16.
- R3: The command word holds the engine opcode in bits [31:27], the slave ID in [23:20], the address in [19:4] and the length code (bytes minus one) in [2:0]. All other bits are zero.
- R4: A length code of 8 or more gives error class 1 (invalid), with no engine register access.
- R5: An opcode outside the ranges of R1/R2 for its direction gives error class 1, with no engine register access.
- R6: A write stores bytes 0..3 (byte 0 in bits [7:0]) at 0x10 and then, only when the length exceeds four, bytes 4..7 at 0x14. Both come before the command word. Bytes beyond the length are sent as zero.
- R7: After a clean read completes, the sequencer reads 0x18 and, only when the length exceeds four, 0x1C. `rsp_rdata` holds the bytes in order with byte 0 in bits [7:0], and bytes beyond the length are zero.
- R8: Status bit 0 is done, bit 1 failure, bit 2 denied and bit 3 dropped. The error bits are ignored until done is read. Once done is read, denied gives class 2, otherwise failure or dropped gives class 3, and otherwise the class is 0.
- R9: If done has not appeared after CLK_MHZ*TIMEOUT_US status reads, the reply carries class 4 (timeout), even if error bits are set.
- R10: `busy` is high from the cycle after acceptance through the one-cycle `rsp_valid` pulse. A request offered while busy is ignored and produces no reply.
- R11: After reset `busy` and `rsp_valid` are low and no engine register is accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered (taken only when not busy) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_opc | input | 8 | Bus opcode |
| req_sid | input | 4 | Slave ID |
| req_addr | input | 16 | Register address |
| req_len_m1 | input | 4 | Bytes minus one |
| req_wdata | input | 64 | Write bytes, byte 0 in [7:0] |
| busy | output | 1 | Transaction in flight |
| rsp_valid | output | 1 | One-cycle reply strobe |
| rsp_err | output | 3 | 0 ok, 1 invalid, 2 denied, 3 I/O error, 4 timeout |
| rsp_rdata | output | 64 | Read bytes, byte 0 in [7:0] |
| bus_wr_en | output | 1 | Engine register write strobe |
| bus_rd_en | output | 1 | Engine register read strobe |
| bus_addr | output | 5 | Engine register offset |
| bus_wdata | output | 32 | Engine register write data |
| bus_rdata | input | 32 | Engine register read data, same cycle |

## Verification
The bench covers all 256 opcodes in both directions. An off-by-one range bound would map a single edge opcode wrongly, or let it through, and a swapped field would corrupt the captured command word. Every length code from 0 to 15 is tried in both directions. This catches a missing reject at 8, an unwanted high data word at exactly four bytes, and stale bytes left unmasked. All eight error-bit combinations are returned behind a delayed done. A wrong priority order would report I/O error where denied is due, and a sequencer that looked at error bits early would stop before done. A never-done engine must see exactly the budgeted number of status reads. A request offered mid-transaction must leave the command word and the reply count untouched.

// File: rtl/cmd_chan_pkg.sv
package cmd_chan_pkg;

    typedef enum logic [2:0] {
        ERR_OK      = 3'd0,
        ERR_INVALID = 3'd1,
        ERR_DENIED  = 3'd2,
        ERR_IO      = 3'd3,
        ERR_TIMEOUT = 3'd4
    } err_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CHECK, S_WR_LO, S_WR_HI, S_ISSUE,
        S_POLL, S_RD_LO, S_RD_HI, S_REPLY
    } state_e;

    localparam int OFS_W = 5;
    localparam logic [OFS_W-1:0] OFS_CMD    = 5'h00;
    localparam logic [OFS_W-1:0] OFS_STATUS = 5'h08;
    localparam logic [OFS_W-1:0] OFS_WLO    = 5'h10;
    localparam logic [OFS_W-1:0] OFS_WHI    = 5'h14;
    localparam logic [OFS_W-1:0] OFS_RLO    = 5'h18;
    localparam logic [OFS_W-1:0] OFS_RHI    = 5'h1C;

    localparam int ST_DONE = 0;
    localparam int ST_FAIL = 1;
    localparam int ST_DENY = 2;
    localparam int ST_DROP = 3;

    localparam int MAX_LEN_M1 = 7;

    // keep the lanes of one 32-bit data word that fall within the length
    function automatic logic [31:0] lane_mask(input logic [2:0] bc, input logic upper);
        logic [31:0] m;
        m = '0;
        for (int b = 0; b < 4; b++) begin
            if ((upper ? b + 4 : b) <= int'(bc))
                m[b*8 +: 8] = 8'hFF;
        end
        return m;
    endfunction

endpackage

// File: rtl/opcode_xlate.sv
module opcode_xlate (
    input  logic       is_write,
    input  logic [7:0] bus_opc,
    output logic       ok,
    output logic [4:0] eng_opc
);
    always_comb begin
        ok      = 1'b1;
        eng_opc = 5'd0;
        if (is_write) begin
            if (bus_opc >= 8'h80)                          eng_opc = 5'd16;
            else if (bus_opc >= 8'h40 && bus_opc <= 8'h5F) eng_opc = 5'd14;
            else if (bus_opc <= 8'h0F)                     eng_opc = 5'd2;
            else if (bus_opc >= 8'h30 && bus_opc <= 8'h37) eng_opc = 5'd0;
            else                                           ok = 1'b0;
        end else begin
            if (bus_opc >= 8'h60 && bus_opc <= 8'h7F)      eng_opc = 5'd15;
            else if (bus_opc >= 8'h20 && bus_opc <= 8'h2F) eng_opc = 5'd13;
            else if (bus_opc >= 8'h38 && bus_opc <= 8'h3F) eng_opc = 5'd1;
            else                                           ok = 1'b0;
        end
    end
endmodule

// File: rtl/cmd_word_pack.sv
module cmd_word_pack (
    input  logic [4:0]  eng_opc,
    input  logic [3:0]  sid,
    input  logic [15:0] addr,
    input  logic [2:0]  bc,
    output logic [31:0] word
);
    // opcode [31:27], zero [26:24], sid [23:20], addr [19:4], zero [3], bc [2:0]
    assign word = {eng_opc, 3'b000, sid, addr, 1'b0, bc};
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
    parameter int LIMIT = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign expired = tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (!tick)   cnt <= '0;
        else if (!expired) cnt <= cnt + 1'b1;
        else              cnt <= '0;
    end
endmodule

// File: rtl/cmd_chan_seq.sv
module cmd_chan_seq
    import cmd_chan_pkg::*;
#(
    parameter int CLK_MHZ    = 100,
    parameter int TIMEOUT_US = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [7:0]  req_opc,
    input  logic [3:0]  req_sid,
    input  logic [15:0] req_addr,
    input  logic [3:0]  req_len_m1,
    input  logic [63:0] req_wdata,
    output logic        busy,
    output logic        rsp_valid,
    output logic [2:0]  rsp_err,
    output logic [63:0] rsp_rdata,
    output logic        bus_wr_en,
    output logic        bus_rd_en,
    output logic [4:0]  bus_addr,
    output logic [31:0] bus_wdata,
    input  logic [31:0] bus_rdata
);
    localparam int TIMEOUT_CYC = CLK_MHZ * TIMEOUT_US;

    state_e state, state_nx;

    logic        r_write;
    logic [7:0]  r_opc;
    logic [3:0]  r_sid;
    logic [15:0] r_addr;
    logic [3:0]  r_len_m1;
    logic [63:0] r_wdata;
    logic [63:0] r_rdata;
    err_e        r_err;

    logic        op_ok;
    logic [4:0]  eng_opc;
    logic [31:0] cmd_word;
    logic        len_ok;
    logic [2:0]  bc;
    logic        wide;
    logic        st_done, st_err;
    logic        poll_tick, poll_expired;

    assign len_ok  = (r_len_m1 <= 4'(MAX_LEN_M1));
    assign bc      = r_len_m1[2:0];
    assign wide    = bc[2];
    assign st_done = bus_rdata[ST_DONE];
    assign st_err  = bus_rdata[ST_DENY] | bus_rdata[ST_FAIL] | bus_rdata[ST_DROP];

    opcode_xlate xlate_i (
        .is_write (r_write),
        .bus_opc  (r_opc),
        .ok       (op_ok),
        .eng_opc  (eng_opc)
    );

    cmd_word_pack pack_i (
        .eng_opc (eng_opc),
        .sid     (r_sid),
        .addr    (r_addr),
        .bc      (bc),
        .word    (cmd_word)
    );

    assign poll_tick = (state == S_POLL) && !st_done;

    poll_timer #(.LIMIT(TIMEOUT_CYC)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (poll_tick),
        .expired (poll_expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (req_valid) state_nx = S_CHECK;
            S_CHECK: begin
                if (!len_ok || !op_ok) state_nx = S_REPLY;
                else if (r_write)      state_nx = S_WR_LO;
                else                   state_nx = S_ISSUE;
            end
            S_WR_LO: state_nx = wide ? S_WR_HI : S_ISSUE;
            S_WR_HI: state_nx = S_ISSUE;
            S_ISSUE: state_nx = S_POLL;
            S_POLL: begin
                if (st_done) state_nx = (st_err || r_write) ? S_REPLY : S_RD_LO;
                else if (poll_expired) state_nx = S_REPLY;
            end
            S_RD_LO: state_nx = wide ? S_RD_HI : S_REPLY;
            S_RD_HI: state_nx = S_REPLY;
            S_REPLY: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // request capture and result collection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_write  <= 1'b0;
            r_opc    <= '0;
            r_sid    <= '0;
            r_addr   <= '0;
            r_len_m1 <= '0;
            r_wdata  <= '0;
            r_rdata  <= '0;
            r_err    <= ERR_OK;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    r_write  <= req_write;
                    r_opc    <= req_opc;
                    r_sid    <= req_sid;
                    r_addr   <= req_addr;
                    r_len_m1 <= req_len_m1;
                    r_wdata  <= req_wdata;
                    r_rdata  <= '0;
                    r_err    <= ERR_OK;
                end
                S_CHECK: if (!len_ok || !op_ok) r_err <= ERR_INVALID;
                S_POLL: begin
                    if (st_done) begin
                        if (bus_rdata[ST_DENY])                          r_err <= ERR_DENIED;
                        else if (bus_rdata[ST_FAIL] || bus_rdata[ST_DROP]) r_err <= ERR_IO;
                        else                                             r_err <= ERR_OK;
                    end else if (poll_expired) begin
                        r_err <= ERR_TIMEOUT;
                    end
                end
                S_RD_LO: r_rdata[31:0]  <= bus_rdata & lane_mask(bc, 1'b0);
                S_RD_HI: r_rdata[63:32] <= bus_rdata & lane_mask(bc, 1'b1);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        bus_wr_en = 1'b0;
        bus_rd_en = 1'b0;
        bus_addr  = OFS_CMD;
        bus_wdata = '0;
        unique case (state)
            S_WR_LO: begin
                bus_wr_en = 1'b1;
                bus_addr  = OFS_WLO;
                bus_wdata = r_wdata[31:0] & lane_mask(bc, 1'b0);
            end
            S_WR_HI: begin
                bus_wr_en = 1'b1;
                bus_addr  = OFS_WHI;
                bus_wdata = r_wdata[63:32] & lane_mask(bc, 1'b1);
            end
            S_ISSUE: begin
                bus_wr_en = 1'b1;
                bus_addr  = OFS_CMD;
                bus_wdata = cmd_word;
            end
            S_POLL: begin
                bus_rd_en = 1'b1;
                bus_addr  = OFS_STATUS;
            end
            S_RD_LO: begin
                bus_rd_en = 1'b1;
                bus_addr  = OFS_RLO;
            end
            S_RD_HI: begin
                bus_rd_en = 1'b1;
                bus_addr  = OFS_RHI;
            end
            default: ;
        endcase
    end

    assign busy      = (state != S_IDLE);
    assign rsp_valid = (state == S_REPLY);
    assign rsp_err   = r_err;
    assign rsp_rdata = r_rdata;

endmodule

// File: rtl/cmd_chan_seq_chk.sv
module cmd_chan_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       busy,
    input logic       rsp_valid,
    input logic [2:0] rsp_err,
    input logic       bus_wr_en,
    input logic       bus_rd_en,
    input logic [4:0] bus_addr
);
    // R10
    access_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en || bus_rd_en) |-> busy);

    // R10
    single_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && !busy));

    // R10
    start_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R6
    rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_en && bus_rd_en));

    // R8
    poll_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == 5'h00) |=> (bus_rd_en && bus_addr == 5'h08));

    // R4
    invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err == 3'd1) |-> $past(!bus_wr_en && !bus_rd_en));

    // R9
    timeout_after_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err == 3'd4) |-> $past(bus_rd_en && bus_addr == 5'h08));
endmodule

bind cmd_chan_seq cmd_chan_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr)
);

// File: tb/cmd_chan_seq_tb_top.sv
module cmd_chan_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ    = 1;
    localparam int TIMEOUT_US = 12;
    localparam int BUDGET     = CLK_MHZ * TIMEOUT_US;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_opc = '0;
    logic [3:0]  req_sid = '0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_len_m1 = '0;
    logic [63:0] req_wdata = '0;
    logic        busy, rsp_valid;
    logic [2:0]  rsp_err;
    logic [63:0] rsp_rdata;
    logic        bus_wr_en, bus_rd_en;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_chan_seq #(.CLK_MHZ(CLK_MHZ), .TIMEOUT_US(TIMEOUT_US)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_opc(req_opc),
        .req_sid(req_sid), .req_addr(req_addr), .req_len_m1(req_len_m1),
        .req_wdata(req_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // ---------------- engine responder ----------------
    logic        log_clr = 1'b0;
    int          poll_delay = 0;
    logic [2:0]  err_bits = '0;     // {drop, deny, fail}
    logic [31:0] rd_lo_val = '0, rd_hi_val = '0;
    int          stat_reads, lo_reads, hi_reads, wr_seq, bus_ops, rsp_count;
    int          pos_wlo, pos_whi, pos_cmd;
    logic [31:0] cmd_val, wlo_val, whi_val;

    always_comb begin
        case (bus_addr)
            5'h08:   bus_rdata = {28'd0, err_bits, (stat_reads >= poll_delay)};
            5'h18:   bus_rdata = rd_lo_val;
            5'h1C:   bus_rdata = rd_hi_val;
            default: bus_rdata = 32'd0;
        endcase
    end

    always @(posedge clk) begin
        if (log_clr) begin
            stat_reads <= 0; lo_reads <= 0; hi_reads <= 0; wr_seq <= 0;
            bus_ops <= 0; rsp_count <= 0;
            pos_wlo <= -1; pos_whi <= -1; pos_cmd <= -1;
            cmd_val <= '0; wlo_val <= '0; whi_val <= '0;
        end else begin
            if (rsp_valid) rsp_count <= rsp_count + 1;
            if (bus_wr_en || bus_rd_en) bus_ops <= bus_ops + 1;
            if (bus_wr_en) begin
                wr_seq <= wr_seq + 1;
                case (bus_addr)
                    5'h00: begin cmd_val <= bus_wdata; pos_cmd <= wr_seq; end
                    5'h10: begin wlo_val <= bus_wdata; pos_wlo <= wr_seq; end
                    5'h14: begin whi_val <= bus_wdata; pos_whi <= wr_seq; end
                    default: ;
                endcase
            end
            if (bus_rd_en) begin
                case (bus_addr)
                    5'h08: stat_reads <= stat_reads + 1;
                    5'h18: lo_reads <= lo_reads + 1;
                    5'h1C: hi_reads <= hi_reads + 1;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- bookkeeping ----------------
    int n_checks = 0, n_fail = 0;
    int cyc = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // ---------------- reference model ----------------
    function automatic int exp_code(input bit w, input int op);
        if (w) begin
            if (op >= 128)             return 16;
            if (op >= 64 && op <= 95)  return 14;
            if (op <= 15)              return 2;
            if (op >= 48 && op <= 55)  return 0;
            return -1;
        end
        if (op >= 96 && op <= 127) return 15;
        if (op >= 32 && op <= 47)  return 13;
        if (op >= 56 && op <= 63)  return 1;
        return -1;
    endfunction

    function automatic logic [63:0] keep_bytes(input logic [63:0] d, input int lm);
        return d & (64'hFFFF_FFFF_FFFF_FFFF >> (64 - 8 * (lm + 1)));
    endfunction

    logic [2:0]  got_err;
    logic [63:0] got_rdata;
    bit          got_rsp;

    task automatic run_req(input bit w, input logic [7:0] op, input logic [3:0] sid,
                           input logic [15:0] addr, input logic [3:0] lm, input logic [63:0] wd);
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
        req_valid = 1'b1; req_write = w; req_opc = op; req_sid = sid;
        req_addr = addr; req_len_m1 = lm; req_wdata = wd;
        @(negedge clk); req_valid = 1'b0;
        got_rsp = 1'b0;
        for (int k = 0; k < BUDGET + 40; k++) begin
            if (rsp_valid) begin
                got_rsp = 1'b1; got_err = rsp_err; got_rdata = rsp_rdata;
                break;
            end
            @(negedge clk);
        end
        if (!got_rsp) check(1'b0, "R10 no reply", 0, 1);
        @(negedge clk);
    endtask

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        check(!busy && !rsp_valid, "R11 idle outputs in reset", {busy, rsp_valid}, 0);
        rst_n = 1'b1;
        log_clr = 1'b1; @(negedge clk); log_clr = 1'b0;
        repeat (4) @(negedge clk);
        check(!busy && !rsp_valid, "R11 idle outputs after reset", {busy, rsp_valid}, 0);
        check(bus_ops == 0, "R11 no bus access after reset", bus_ops, 0);

        // R1 R2 R3 R5: every opcode, both directions
        poll_delay = 0; err_bits = '0;
        for (int w = 0; w < 2; w++) begin
            for (int op = 0; op < 256; op++) begin
                int code;
                logic [15:0] a;
                logic [31:0] exp_cmd;
                code = exp_code(w[0], op);
                a = {8'(op), 8'(~op)};
                run_req(w[0], 8'(op), 4'(op), a, 4'd0, 64'hA5);
                if (code < 0) begin
                    check(got_err == 3'd1, "R5 bad opcode class", got_err, 1);
                    check(bus_ops == 0, "R5 bad opcode bus access", bus_ops, 0);
                end else begin
                    exp_cmd = (32'(code) << 27) | (32'(op & 15) << 20) | (32'(a) << 4);
                    check(got_err == 3'd0, w ? "R2 write class" : "R1 read class", got_err, 0);
                    check(cmd_val == exp_cmd, w ? "R2 R3 write cmd word" : "R1 R3 read cmd word",
                          cmd_val, exp_cmd);
                end
            end
        end

        // R3 bc field and R4 R6 R7: every length code
        for (int w = 0; w < 2; w++) begin
            for (int lm = 0; lm < 16; lm++) begin
                logic [63:0] wd;
                wd = 64'h8877_6655_4433_2211 ^ {8{8'(lm * 16)}};
                rd_lo_val = 32'hD4C3_B2A1 ^ 32'(lm);
                rd_hi_val = 32'hF8E7_D6C5 ^ 32'(lm);
                run_req(w[0], w ? 8'h41 : 8'h61, 4'h7, 16'h3C5A, 4'(lm), wd);
                if (lm >= 8) begin
                    check(got_err == 3'd1, "R4 long length class", got_err, 1);
                    check(bus_ops == 0, "R4 long length bus access", bus_ops, 0);
                end else begin
                    check(got_err == 3'd0, "R4 legal length class", got_err, 0);
                    check(cmd_val[2:0] == 3'(lm), "R3 length field", cmd_val[2:0], lm);
                    if (w) begin
                        logic [63:0] kd;
                        kd = keep_bytes(wd, lm);
                        check(wlo_val == kd[31:0], "R6 low data word", wlo_val, kd[31:0]);
                        check(pos_wlo >= 0 && pos_wlo < pos_cmd, "R6 low word before cmd", pos_wlo, pos_cmd);
                        if (lm > 3) begin
                            check(whi_val == kd[63:32], "R6 high data word", whi_val, kd[63:32]);
                            check(pos_whi > pos_wlo && pos_whi < pos_cmd, "R6 high word order", pos_whi, pos_cmd);
                        end else begin
                            check(pos_whi == -1, "R6 no high word", pos_whi, -1);
                        end
                    end else begin
                        logic [63:0] kr;
                        kr = keep_bytes({rd_hi_val, rd_lo_val}, lm);
                        check(got_rdata == kr, "R7 read data", got_rdata, kr);
                        check(lo_reads == 1, "R7 low read count", lo_reads, 1);
                        check(hi_reads == ((lm > 3) ? 1 : 0), "R7 high read count", hi_reads, (lm > 3) ? 1 : 0);
                    end
                end
            end
        end

        // R8: every error-bit combination behind a delayed done
        poll_delay = 3;
        for (int f = 0; f < 8; f++) begin
            int exp_e;
            err_bits = 3'(f);
            exp_e = f[1] ? 2 : ((f[0] || f[2]) ? 3 : 0);
            run_req(1'b0, 8'h38, 4'h2, 16'h0110, 4'd0, 64'd0);
            check(got_err == 3'(exp_e), "R8 error priority", got_err, exp_e);
            check(stat_reads == 4, "R8 polls until done", stat_reads, 4);
            check(lo_reads == ((exp_e == 0) ? 1 : 0), "R8 data read only when clean",
                  lo_reads, (exp_e == 0) ? 1 : 0);
        end

        // R9: never done
        poll_delay = 1000;
        for (int f = 0; f < 2; f++) begin
            err_bits = f[0] ? 3'b111 : 3'b000;
            run_req(f[0], f[0] ? 8'h05 : 8'h25, 4'h9, 16'h0203, 4'd1, 64'h1234);
            check(got_err == 3'd4, "R9 timeout class", got_err, 4);
            check(stat_reads == BUDGET, "R9 status read budget", stat_reads, BUDGET);
        end

        // R10: request offered while busy is ignored
        poll_delay = 6; err_bits = '0;
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
        req_valid = 1'b1; req_write = 1'b1; req_opc = 8'h40; req_sid = 4'h1;
        req_addr = 16'h1234; req_len_m1 = 4'd0; req_wdata = 64'h77;
        @(negedge clk); req_valid = 1'b0;
        check(busy == 1'b1, "R10 busy after accept", busy, 1);
        @(negedge clk); @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_opc = 8'h70; req_sid = 4'hE; req_addr = 16'hFFFF;
        @(negedge clk); @(negedge clk);
        req_valid = 1'b0;
        repeat (30) @(negedge clk);
        check(rsp_count == 1, "R10 single reply", rsp_count, 1);
        check(cmd_val == 32'h7011_2340, "R10 cmd word of first request", cmd_val, 32'h7011_2340);
        check(busy == 1'b0, "R10 idle after reply", busy, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule